// File: doc/BRIEF.md
# Shadowed BCD Real-Time Clock Register Bank

This block is the timekeeping core of a real-time clock. A set of live counters holds the century, year, month, date, day of the week, hours, minutes and seconds, all in packed BCD. The counters advance by one second on each pulse of an external 1 Hz tick. Software never reads the live counters directly. It sees a second bank of byte registers that is copied from the counters in a single cycle after each increment. All of this sits behind a 16-entry byte window on a simple parallel bus.

A control byte carries two freeze bits. One freezes the visible copies so that software can read a coherent time while the counters keep running. The other freezes the copies so that software can load a new time; the loaded values move into the live counters together when that bit is cleared. A stop bit in the seconds byte suspends counting. On reset all three bits are cleared.

Top module: `rtc_shadow_bank`

## Requirements
- R1: After reset the control byte (offset 8) and the stop bit read 0, and the visible time reads 20 00-01-01, day 01, 00:00:00.
- R2: Each tick that is not suppressed advances the seconds by one in BCD. Seconds roll from 59 to 00 into the minutes, minutes roll from 59 to 00 into the hours, and hours roll from 23 to 00.
- R3: At a day rollover, day-of-week steps from 7 back to 1. Date wraps to 01 after 31, 30, or 28/29 for month 02 (29 when the BCD year is divisible by 4). Month wraps from 12 to 01. Year wraps from 99 to 00 and carries into the century byte.
- R4: When no freeze bit is set, all visible time bytes take the new counter value together on the clock edge that follows the tick edge.
- R5: While READ (control bit 6) is 1, the visible time bytes do not change, but the live counters keep counting.
- R6: A tick that arrives in the same cycle in which READ is set still completes its refresh of the visible copies.
- R7: Clearing READ does not by itself update the copies. The next update happens at the next tick.
- R8: While WRITE (control bit 7) is 1, refreshes stop and software writes to the time bytes are held. A control write that clears WRITE loads all time bytes (offsets 15 to 9 and 1) into the live counters at once. The next increment happens at the following tick.
- R9: While STOP (bit 7 of the seconds byte at offset 9) is 1, ticks do not advance the time. After STOP is cleared, the next tick advances it.
- R10: A write to a time byte while neither freeze bit is set is replaced at the next refresh and never reaches the live counters.
- R11: Register map: 15 year, 14 month, 13 date, 12 day, 11 hours, 10 minutes, 9 seconds, 8 control, 1 century. Control reads back only bits 7:6. All other offsets read 0. With cs low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second |
| cs | input | 1 | Chip select for the register window |
| we | input | 1 | Single-cycle write strobe, qualified by cs |
| addr | input | ADDR_W | Register offset inside the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data of the addressed byte |

## Verification
The bench builds the block with its default parameters: a 4-bit window and byte-wide registers. The tick is an input, so the bench loads times close to each boundary through the WRITE sequence and then pulses the tick a few times. This reaches the minute, hour, month, leap-February, year and century rollovers in a few dozen cycles. Because the tick can be placed in any chosen cycle, the bench can also land a tick on the same edge as a READ-setting write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] cent;
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] month;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RESET_TIME = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                       date: 8'h01, day: 8'h01, hour: 8'h00,
                                       min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    int yb;
    yb = int'(y[7:4]) * 10 + int'(y[3:0]);
    case (m)
      8'h02: return ((yb % 4) == 0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);
  always_comb begin
    nxt = cur;
    if (cur.sec == 8'h59) begin
      nxt.sec = 8'h00;
      if (cur.min == 8'h59) begin
        nxt.min = 8'h00;
        if (cur.hour == 8'h23) begin
          nxt.hour = 8'h00;
          nxt.day  = (cur.day >= 8'h07) ? 8'h01 : bcd_inc(cur.day);
          if (cur.date >= month_len(cur.month, cur.year)) begin
            nxt.date = 8'h01;
            if (cur.month >= 8'h12) begin
              nxt.month = 8'h01;
              if (cur.year == 8'h99) begin
                nxt.year = 8'h00;
                nxt.cent = (cur.cent == 8'h99) ? 8'h00 : bcd_inc(cur.cent);
              end else begin
                nxt.year = bcd_inc(cur.year);
              end
            end else begin
              nxt.month = bcd_inc(cur.month);
            end
          end else begin
            nxt.date = bcd_inc(cur.date);
          end
        end else begin
          nxt.hour = bcd_inc(cur.hour);
        end
      end else begin
        nxt.min = bcd_inc(cur.min);
      end
    end else begin
      nxt.sec = bcd_inc(cur.sec);
    end
  end
endmodule

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inc,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t live
);
  rtc_time_t nxt;

  rtc_calendar_next u_next (.cur(live), .nxt(nxt));

  always_ff @(posedge clk) begin
    if (rst)       live <= RESET_TIME;
    else if (load) live <= load_val;
    else if (inc)  live <= nxt;
  end

  // R2: the counters move only on an increment or a load
  assert_hold_without_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(live));
endmodule

// File: rtl/rtc_shadow_copies.sv
module rtc_shadow_copies
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh,
  input  rtc_time_t         live,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output rtc_time_t         copies
);
  localparam logic [ADDR_W-1:0] OFS_YEAR  = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] OFS_MONTH = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] OFS_DATE  = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] OFS_DAY   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_HOUR  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] OFS_MIN   = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] OFS_SEC   = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] OFS_CENT  = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      copies <= RESET_TIME;
    end else if (refresh) begin
      copies <= live;
    end else if (wr_en) begin
      case (addr)
        OFS_YEAR:  copies.year  <= wdata;
        OFS_MONTH: copies.month <= wdata;
        OFS_DATE:  copies.date  <= wdata;
        OFS_DAY:   copies.day   <= wdata;
        OFS_HOUR:  copies.hour  <= wdata;
        OFS_MIN:   copies.min   <= wdata;
        OFS_SEC:   copies.sec   <= {1'b0, wdata[BYTE_W-2:0]};
        OFS_CENT:  copies.cent  <= wdata;
        default: ;
      endcase
    end
  end

  // R5: without a refresh or a bus write the copies stay put
  assert_copies_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!refresh && !wr_en) |=> $stable(copies));
endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_SEC  = ADDR_W'(9);

  logic      read_q, write_q, stop_q, pending;
  logic      wr, wr_ctrl, load, freeze, count_en;
  rtc_time_t live, copies, load_val;

  assign wr       = cs && we;
  assign wr_ctrl  = wr && (addr == OFS_CTRL);
  assign load     = wr_ctrl && write_q && !wdata[7];
  assign freeze   = read_q || write_q;
  assign count_en = tick && !stop_q && !load;

  always_comb begin
    load_val = copies;
    load_val.sec[7] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      read_q  <= 1'b0;
      write_q <= 1'b0;
      stop_q  <= 1'b0;
      pending <= 1'b0;
    end else begin
      pending <= count_en && !freeze;
      if (wr_ctrl) begin
        write_q <= wdata[7];
        read_q  <= wdata[6];
      end
      if (wr && addr == OFS_SEC) stop_q <= wdata[7];
    end
  end

  rtc_live_counter u_live (
    .clk(clk), .rst(rst), .inc(count_en), .load(load),
    .load_val(load_val), .live(live)
  );

  rtc_shadow_copies #(.ADDR_W(ADDR_W)) u_copies (
    .clk(clk), .rst(rst), .refresh(pending), .live(live),
    .wr_en(wr), .addr(addr), .wdata(wdata), .copies(copies)
  );

  always_comb begin
    rdata = 8'h00;
    if (cs) begin
      case (addr)
        ADDR_W'(15): rdata = copies.year;
        ADDR_W'(14): rdata = copies.month;
        ADDR_W'(13): rdata = copies.date;
        ADDR_W'(12): rdata = copies.day;
        ADDR_W'(11): rdata = copies.hour;
        ADDR_W'(10): rdata = copies.min;
        OFS_SEC:     rdata = {stop_q, copies.sec[6:0]};
        OFS_CTRL:    rdata = {write_q, read_q, 6'b0};
        ADDR_W'(1):  rdata = copies.cent;
        default:     rdata = 8'h00;
      endcase
    end
  end

  // R1: reset clears the freeze and stop bits
  assert_flags_clear_R1: assert property (@(posedge clk)
    rst |=> (!read_q && !write_q && !stop_q));

  // R8: a falling WRITE commits the copies to the counters
  assert_load_commits_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (live == $past(load_val)));

  // R9: while stopped the counters change only through a load
  assert_stop_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !load) |=> $stable(live));

  // R4: a pending refresh copies the counters verbatim
  assert_refresh_copies_R4: assert property (@(posedge clk) disable iff (rst)
    pending |=> (copies == $past(live)));
endmodule

// File: tb/rtc_shadow_bank_test.sv
module rtc_shadow_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rtc_shadow_bank #(.ADDR_W(4)) uut (
    .clk(clk), .rst(rst), .tick(tick), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1;
    vectors++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s offset %0d: got %h expected %h", req, a, rdata, exp);
    end
    cs = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, dt, dy, h, mi, s);
    bus_wr(4'd8, 8'h80);
    bus_wr(4'd1, c);  bus_wr(4'd15, y); bus_wr(4'd14, mo); bus_wr(4'd13, dt);
    bus_wr(4'd12, dy); bus_wr(4'd11, h); bus_wr(4'd10, mi); bus_wr(4'd9, s);
    bus_wr(4'd8, 8'h00);
  endtask

  task automatic t_reset();
    chk(4'd8, 8'h00, "R1"); chk(4'd9, 8'h00, "R1"); chk(4'd10, 8'h00, "R1");
    chk(4'd11, 8'h00, "R1"); chk(4'd12, 8'h01, "R1"); chk(4'd13, 8'h01, "R1");
    chk(4'd14, 8'h01, "R1"); chk(4'd15, 8'h00, "R1"); chk(4'd1, 8'h20, "R1");
  endtask

  task automatic t_map();
    chk(4'd0, 8'h00, "R11"); chk(4'd5, 8'h00, "R11");
    bus_wr(4'd8, 8'hFF);
    chk(4'd8, 8'hC0, "R11");
    bus_wr(4'd8, 8'h00);
    chk(4'd8, 8'h00, "R11");
    @(negedge clk); cs = 1'b0; addr = 4'd1; #1;
    vectors++;
    if (rdata !== 8'h00) begin
      fails++; $display("FAIL R11 cs low: got %h expected 00", rdata);
    end
  endtask

  task automatic t_clock_roll();
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    tick1();
    chk(4'd9, 8'h59, "R4"); chk(4'd10, 8'h59, "R4");
    tick1();
    chk(4'd9, 8'h00, "R2"); chk(4'd10, 8'h00, "R2"); chk(4'd11, 8'h00, "R2");
    chk(4'd12, 8'h01, "R3"); chk(4'd13, 8'h01, "R3"); chk(4'd14, 8'h03, "R3");
  endtask

  task automatic t_calendar();
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    tick1();
    chk(4'd13, 8'h29, "R3 leap"); chk(4'd14, 8'h02, "R3 leap"); chk(4'd12, 8'h04, "R3");
    set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    tick1();
    chk(4'd13, 8'h01, "R3 30-day"); chk(4'd14, 8'h05, "R3 30-day");
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    tick1();
    chk(4'd15, 8'h00, "R3 year"); chk(4'd1, 8'h21, "R3 century");
    chk(4'd14, 8'h01, "R3 month"); chk(4'd13, 8'h01, "R3 date");
  endtask

  task automatic t_read_freeze();
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h10, 8'h00, 8'h00);
    bus_wr(4'd8, 8'h40);
    tick1(); tick1(); tick1();
    chk(4'd9, 8'h00, "R5"); chk(4'd8, 8'h40, "R5");
    bus_wr(4'd8, 8'h00);
    chk(4'd9, 8'h00, "R7");
    tick1();
    chk(4'd9, 8'h04, "R5 counters ran");
  endtask

  task automatic t_read_race();
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h10, 8'h00, 8'h04);
    @(negedge clk);
    tick = 1'b1; cs = 1'b1; we = 1'b1; addr = 4'd8; wdata = 8'h40;
    @(negedge clk);
    tick = 1'b0; cs = 1'b0; we = 1'b0;
    @(negedge clk);
    chk(4'd9, 8'h05, "R6");
    tick1(); tick1();
    chk(4'd9, 8'h05, "R6 frozen");
    bus_wr(4'd8, 8'h00);
    tick1();
    chk(4'd9, 8'h08, "R6 resume");
  endtask

  task automatic t_write_load();
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h08, 8'h30, 8'h00);
    bus_wr(4'd8, 8'h80);
    bus_wr(4'd9, 8'h45); bus_wr(4'd10, 8'h15);
    tick1();
    chk(4'd9, 8'h45, "R8 held"); chk(4'd8, 8'h80, "R8");
    bus_wr(4'd8, 8'h00);
    chk(4'd9, 8'h45, "R8 no step"); chk(4'd10, 8'h15, "R8");
    tick1();
    chk(4'd9, 8'h46, "R8 loaded"); chk(4'd10, 8'h15, "R8 loaded");
  endtask

  task automatic t_stale_write();
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h00, 8'h00);
    bus_wr(4'd9, 8'h33);
    chk(4'd9, 8'h33, "R10");
    tick1();
    chk(4'd9, 8'h01, "R10 overwritten");
  endtask

  task automatic t_stop();
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h12, 8'h00, 8'h00);
    bus_wr(4'd9, 8'h80);
    chk(4'd9, 8'h80, "R9");
    tick1(); tick1();
    chk(4'd9, 8'h80, "R9 stopped");
    bus_wr(4'd9, 8'h00);
    tick1();
    chk(4'd9, 8'h01, "R9 resumed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_clock_roll();
    t_calendar();
    t_read_freeze();
    t_read_race();
    t_write_load();
    t_stale_write();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule